// File: doc/BRIEF.md
# Two-Stage Sub-second Time Base with Phase Shift

This block turns a kernel clock into a once-per-second calendar tick. It does so in two counting stages. The first stage is a short down-counter that emits an intermediate tick once every `div_a + 1` kernel clocks. The second stage is a down-counter clocked by that intermediate tick. It emits the second tick once every `div_s + 1` intermediate ticks. With factors 127 and 255, a 32.768 kHz clock gives exactly 1 Hz.

The value of the second stage is the sub-second count and is brought out as `subsec`. That counter is 16 bits wide: the low 15 bits hold the normal range and the top bit catches values pushed past that range.

A phase-shift request adds a 15-bit fraction to the sub-second counter, which delays the time base. It can also issue one extra second tick; together with the added fraction, that advances the time base by one second minus the fraction. An accepted request raises a busy flag until it takes effect at the next intermediate tick. While the init input is high, both stages sit at their reload values and no ticks come out.

Top module: `subsec_timebase`

## Requirements
- R1: While `rst` is high (synchronous, active-high), `apre_tick`, `sec_tick` and `shift_busy` read 0 and `subsec` reads `div_s` zero-extended to 16 bits.
- R2: While `init_mode` is high, no `apre_tick` or `sec_tick` pulse is produced, `subsec` holds `div_s`, and shift requests are ignored.
- R3: After `init_mode` falls, the first `apre_tick` pulse appears on the (`div_a`+1)-th clock edge. Further pulses, each one cycle long, follow every `div_a`+1 clocks.
- R4: `subsec` decrements by one on each `apre_tick` and holds its value otherwise. An `apre_tick` seen with `subsec` at 0 reloads it with `div_s` and raises `sec_tick` for one cycle, so seconds repeat every (`div_a`+1)(`div_s`+1) clocks.
- R5: A one-cycle `shift_req` with `subsec[15]` = 0 (and no shift already pending) raises `shift_busy` on the next cycle. The shift is not applied on the request cycle. It is applied at the next `apre_tick`: the counter takes its normal next value plus `shift_frac`, and `shift_busy` falls at that same edge.
- R6: An applied shift delays every later `sec_tick` by `shift_frac`·(`div_a`+1) clocks. The counter may then lie above `div_s` and counts down from there, which lengthens the current second.
- R7: When `shift_add_sec` is 1 with an accepted request, one extra `sec_tick` pulse appears in the cycle after the shift is applied.
- R8: A `shift_req` seen while `subsec[15]` = 1 is rejected: `shift_busy` stays 0 and `subsec` keeps decrementing by one per `apre_tick` with nothing added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst | input | 1 | Synchronous active-high reset |
| init_mode | input | 1 | Holds both stages at reload and blocks ticks |
| div_a | input | AW (7) | First-stage factor, divides by value + 1 |
| div_s | input | SW (15) | Second-stage factor, divides by value + 1 |
| shift_req | input | 1 | One-cycle phase-shift request |
| shift_frac | input | SW (15) | Fraction added to the sub-second counter |
| shift_add_sec | input | 1 | Issue one extra second tick with the shift |
| apre_tick | output | 1 | Intermediate tick, one cycle wide |
| sec_tick | output | 1 | Second tick, one cycle wide |
| subsec | output | SW+1 (16) | Sub-second counter including overflow bit |
| shift_busy | output | 1 | Shift accepted but not yet applied |

## Verification
The hardest case to reach is rejection of a shift. It only happens while the overflow bit of the sub-second counter is set, and that state arises only after an earlier shift with a near-maximal fraction.

To get there, the stimulus re-enters init mode and reloads the first stage with a factor of zero, so an intermediate tick occurs every clock. It then requests a shift of 0x7FFF on a known second boundary. A second request is made while the counter reads 0x8000, and the bench checks that the busy flag stays low and the count simply keeps falling.

Delay and extra-second shifts are timed from predicted second boundaries. The scoreboard therefore holds exact expected edge numbers for every second tick.

// File: rtl/ts_pkg.sv
package ts_pkg;

  typedef enum logic [0:0] {
    SH_IDLE = 1'b0,
    SH_WAIT = 1'b1
  } shift_state_t;

  localparam int TS_DEF_AW = 7;
  localparam int TS_DEF_SW = 15;

endpackage

// File: rtl/ts_async_div.sv
module ts_async_div #(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold,
  input  logic [AW-1:0] div,
  output logic          tick
);

  logic [AW-1:0] cnt;
  logic          at_zero;

  assign at_zero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      cnt  <= div;
      tick <= 1'b0;
    end else if (at_zero) begin
      cnt  <= div;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt - AW'(1);
      tick <= 1'b0;
    end
  end

endmodule

// File: rtl/ts_shift_ctl.sv
module ts_shift_ctl
  import ts_pkg::*;
#(
  parameter int SW = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold,
  input  logic          req,
  input  logic [SW-1:0] frac_in,
  input  logic          add_in,
  input  logic          ovf,
  input  logic          tick,
  output logic          apply,
  output logic [SW-1:0] frac,
  output logic          add_sec,
  output logic          busy
);

  shift_state_t state;
  logic         accept;

  assign accept = req && !ovf && (state == SH_IDLE);
  assign apply  = (state == SH_WAIT) && tick;
  assign busy   = (state == SH_WAIT);

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      state   <= SH_IDLE;
      frac    <= '0;
      add_sec <= 1'b0;
    end else begin
      case (state)
        SH_IDLE: begin
          if (accept) begin
            state   <= SH_WAIT;
            frac    <= frac_in;
            add_sec <= add_in;
          end
        end
        SH_WAIT: begin
          if (tick) begin
            state <= SH_IDLE;
          end
        end
        default: state <= SH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ts_sync_ctr.sv
module ts_sync_ctr #(
  parameter int SW = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold,
  input  logic          tick,
  input  logic [SW-1:0] div,
  input  logic          apply,
  input  logic [SW-1:0] frac,
  input  logic          add_sec,
  output logic [SW:0]   ss,
  output logic          sec_tick
);

  localparam int CW = SW + 1;

  logic [CW-1:0] stepped;
  logic [CW-1:0] next_ss;
  logic          wrap;
  logic          normal;
  logic          owe;
  logic          owe_next;

  always_comb begin
    wrap     = (ss == '0);
    stepped  = wrap ? {1'b0, div} : (ss - CW'(1));
    next_ss  = apply ? (stepped + {1'b0, frac}) : stepped;
    normal   = tick && wrap;
    owe_next = (owe && normal) || (apply && add_sec);
  end

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      ss       <= {1'b0, div};
      sec_tick <= 1'b0;
      owe      <= 1'b0;
    end else begin
      sec_tick <= normal || owe;
      owe      <= owe_next;
      if (tick) begin
        ss <= next_ss;
      end
    end
  end

endmodule

// File: rtl/subsec_timebase.sv
module subsec_timebase #(
  parameter int AW = ts_pkg::TS_DEF_AW,
  parameter int SW = ts_pkg::TS_DEF_SW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          init_mode,
  input  logic [AW-1:0] div_a,
  input  logic [SW-1:0] div_s,
  input  logic          shift_req,
  input  logic [SW-1:0] shift_frac,
  input  logic          shift_add_sec,
  output logic          apre_tick,
  output logic          sec_tick,
  output logic [SW:0]   subsec,
  output logic          shift_busy
);

  logic          apply_w;
  logic [SW-1:0] frac_w;
  logic          add_w;

  ts_async_div #(.AW(AW)) u_adiv (
    .clk  (clk),
    .rst  (rst),
    .hold (init_mode),
    .div  (div_a),
    .tick (apre_tick)
  );

  ts_shift_ctl #(.SW(SW)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .hold    (init_mode),
    .req     (shift_req),
    .frac_in (shift_frac),
    .add_in  (shift_add_sec),
    .ovf     (subsec[SW]),
    .tick    (apre_tick),
    .apply   (apply_w),
    .frac    (frac_w),
    .add_sec (add_w),
    .busy    (shift_busy)
  );

  ts_sync_ctr #(.SW(SW)) u_sctr (
    .clk      (clk),
    .rst      (rst),
    .hold     (init_mode),
    .tick     (apre_tick),
    .div      (div_s),
    .apply    (apply_w),
    .frac     (frac_w),
    .add_sec  (add_w),
    .ss       (subsec),
    .sec_tick (sec_tick)
  );

endmodule

// File: rtl/ts_timebase_chk.sv
module ts_timebase_chk #(
  parameter int AW = 7,
  parameter int SW = 15
) (
  input logic          clk,
  input logic          rst,
  input logic          init_mode,
  input logic [AW-1:0] div_a,
  input logic          shift_req,
  input logic          apre_tick,
  input logic          sec_tick,
  input logic [SW:0]   subsec,
  input logic          shift_busy
);

  assert_init_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    init_mode |=> (!sec_tick && !apre_tick));

  assert_tick_single_R3: assert property (@(posedge clk) disable iff (rst)
    (apre_tick && ($past(div_a) != '0) && !init_mode) |=> !apre_tick);

  assert_wrap_emits_R4: assert property (@(posedge clk) disable iff (rst)
    (apre_tick && (subsec == '0) && !init_mode) |=> sec_tick);

  assert_hold_between_R4: assert property (@(posedge clk) disable iff (rst)
    (!apre_tick && !init_mode) |=> $stable(subsec));

  assert_accept_R5: assert property (@(posedge clk) disable iff (rst)
    (shift_req && !subsec[SW] && !shift_busy && !init_mode) |=> shift_busy);

  assert_busy_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (shift_busy && apre_tick) |=> !shift_busy);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    (shift_req && subsec[SW] && !shift_busy) |=> !shift_busy);

endmodule

bind subsec_timebase ts_timebase_chk #(.AW(AW), .SW(SW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .init_mode  (init_mode),
  .div_a      (div_a),
  .shift_req  (shift_req),
  .apre_tick  (apre_tick),
  .sec_tick   (sec_tick),
  .subsec     (subsec),
  .shift_busy (shift_busy)
);

// File: tb/subsec_timebase_tb.sv
module subsec_timebase_tb;

  localparam int AW = 7;
  localparam int SW = 15;

  logic          clk = 1'b0;
  logic          rst;
  logic          init_mode;
  logic [AW-1:0] div_a;
  logic [SW-1:0] div_s;
  logic          shift_req;
  logic [SW-1:0] shift_frac;
  logic          shift_add_sec;
  logic          apre_tick;
  logic          sec_tick;
  logic [SW:0]   subsec;
  logic          shift_busy;

  typedef struct {
    int    when;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   ecount = 0;
  int   n_cmp  = 0;
  int   n_bad  = 0;
  bit   done   = 1'b0;

  always #10 clk = ~clk;

  always @(posedge clk) ecount <= ecount + 1;

  subsec_timebase #(.AW(AW), .SW(SW)) u_dut (
    .clk           (clk),
    .rst           (rst),
    .init_mode     (init_mode),
    .div_a         (div_a),
    .div_s         (div_s),
    .shift_req     (shift_req),
    .shift_frac    (shift_frac),
    .shift_add_sec (shift_add_sec),
    .apre_tick     (apre_tick),
    .sec_tick      (sec_tick),
    .subsec        (subsec),
    .shift_busy    (shift_busy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at edge %0d: actual %0d expected %0d", tag, ecount, act, exp);
    end
  endtask

  task automatic push_tick(input int when, input string tag);
    exp_t e;
    e.when = when;
    e.tag  = tag;
    exp_q.push_back(e);
  endtask

  task automatic wait_edge(input int e);
    while (ecount < e) @(negedge clk);
  endtask

  // scoreboard monitor: every second tick must match the next expected edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      while (exp_q.size() > 0 && exp_q[0].when < ecount) begin
        chk(1'b0, {exp_q[0].tag, " missed sec_tick"}, ecount, exp_q[0].when);
        void'(exp_q.pop_front());
      end
      if (sec_tick) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R4 unexpected sec_tick", ecount, -1);
        end else begin
          chk(exp_q[0].when == ecount, {exp_q[0].tag, " sec_tick time"}, ecount, exp_q[0].when);
          void'(exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    wait (ecount > 20000);
    if (!done) begin
      done = 1'b1;
      chk(1'b0, "watchdog", ecount, 20000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int  base;
    int  t;
    bit  seen_apre;
    rst           = 1'b1;
    init_mode     = 1'b1;
    div_a         = 7'd3;
    div_s         = 15'd4;
    shift_req     = 1'b0;
    shift_frac    = '0;
    shift_add_sec = 1'b0;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk(apre_tick == 1'b0, "R1 apre_tick", int'(apre_tick), 0);
    chk(sec_tick == 1'b0, "R1 sec_tick", int'(sec_tick), 0);
    chk(subsec == 16'd4, "R1 subsec", int'(subsec), 4);
    chk(shift_busy == 1'b0, "R1 shift_busy", int'(shift_busy), 0);

    // R2 init mode holds everything, shift ignored
    rst = 1'b0;
    seen_apre = 1'b0;
    for (int i = 0; i < 30; i++) begin
      if (i == 5) begin
        shift_req = 1'b1;
        shift_frac = 15'd9;
      end else begin
        shift_req = 1'b0;
      end
      @(negedge clk);
      if (apre_tick) seen_apre = 1'b1;
    end
    chk(seen_apre == 1'b0, "R2 apre_tick in init", int'(seen_apre), 0);
    chk(subsec == 16'd4, "R2 subsec held", int'(subsec), 4);
    chk(shift_busy == 1'b0, "R2 request ignored", int'(shift_busy), 0);

    // release, A = 4, period 20
    init_mode = 1'b0;
    base = ecount;
    for (int k = 0; k < 3; k++) push_tick(base + 21 + 20 * k, "R4");
    wait_edge(base + 4);
    chk(apre_tick == 1'b1, "R3 first apre_tick", int'(apre_tick), 1);
    wait_edge(base + 5);
    chk(apre_tick == 1'b0, "R3 apre_tick width", int'(apre_tick), 0);
    chk(subsec == 16'd3, "R4 decrement", int'(subsec), 3);
    wait_edge(base + 7);
    chk(subsec == 16'd3, "R4 hold between ticks", int'(subsec), 3);
    wait_edge(base + 8);
    chk(apre_tick == 1'b1, "R3 apre period", int'(apre_tick), 1);

    // R5/R6 delaying shift on a second boundary
    t = base + 61;
    wait_edge(t);
    shift_frac = 15'd3;
    shift_add_sec = 1'b0;
    shift_req = 1'b1;
    @(negedge clk);
    shift_req = 1'b0;
    chk(shift_busy == 1'b1, "R5 busy raised", int'(shift_busy), 1);
    chk(subsec == 16'd4, "R5 not applied on write", int'(subsec), 4);
    wait_edge(t + 3);
    chk(shift_busy == 1'b1, "R5 busy until tick", int'(shift_busy), 1);
    chk(subsec == 16'd4, "R5 still unapplied", int'(subsec), 4);
    wait_edge(t + 4);
    chk(shift_busy == 1'b0, "R5 busy cleared", int'(shift_busy), 0);
    chk(subsec == 16'd6, "R6 above reload", int'(subsec), 6);
    push_tick(t + 32, "R6");
    push_tick(t + 52, "R6");

    // R7 shift with extra second
    t = t + 52;
    wait_edge(t);
    shift_frac = 15'd5;
    shift_add_sec = 1'b1;
    shift_req = 1'b1;
    @(negedge clk);
    shift_req = 1'b0;
    shift_add_sec = 1'b0;
    push_tick(t + 5, "R7");
    push_tick(t + 40, "R6");
    push_tick(t + 60, "R6");
    wait_edge(t + 4);
    chk(subsec == 16'd8, "R7 fraction added", int'(subsec), 8);
    wait_edge(t + 62);

    // R8 overflow rejection with a tick every clock
    init_mode = 1'b1;
    div_a = 7'd0;
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R4 all ticks seen", exp_q.size(), 0);
    init_mode = 1'b0;
    base = ecount;
    push_tick(base + 6, "R4");
    t = base + 6;
    wait_edge(t);
    shift_frac = 15'h7FFF;
    shift_req = 1'b1;
    @(negedge clk);
    shift_req = 1'b0;
    chk(shift_busy == 1'b1, "R5 busy raised", int'(shift_busy), 1);
    chk(subsec == 16'd3, "R5 not applied on write", int'(subsec), 3);
    wait_edge(t + 2);
    chk(subsec == 16'h8001, "R6 overflow bit set", int'(subsec), 32769);
    chk(shift_busy == 1'b0, "R5 busy cleared", int'(shift_busy), 0);
    wait_edge(t + 3);
    chk(subsec == 16'h8000, "R8 pre-request count", int'(subsec), 32768);
    shift_frac = 15'h0010;
    shift_req = 1'b1;
    @(negedge clk);
    shift_req = 1'b0;
    chk(shift_busy == 1'b0, "R8 request rejected", int'(shift_busy), 0);
    wait_edge(t + 6);
    chk(subsec == 16'h7FFD, "R8 count unaffected", int'(subsec), 32765);
    chk(shift_busy == 1'b0, "R8 still idle", int'(shift_busy), 0);
    wait_edge(t + 30);
    chk(exp_q.size() == 0, "R4 no pending ticks", exp_q.size(), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule